// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the data path at the heart of a small 8-bit processor core. Each cycle in which it is enabled, it combines an accumulator value with a second operand. An operation code selects the operation, and some operations also use a carry input. The block then registers an 8-bit result and a byte of condition flags. The surrounding core decodes instructions, fetches operands and writes the registered result back into its accumulator. This block does none of those jobs.

The operations are: add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, and a one-bit rotate of the accumulator through the carry, either left or right. The flag byte reports six conditions:

- sign
- zero
- half-carry out of the low nibble
- parity/overflow
- subtract
- carry

The parity/overflow flag has a double meaning. It gives even parity after a logical operation and signed overflow after an arithmetic one. Rotates leave the sign, zero and parity/overflow flags as they were. Compare updates the flags but leaves the result register alone.

Top module: `accum_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` and `flags` both become 0x00.
- R2: While `en` is low, `result` and `flags` keep their values, whatever `op` and the data inputs carry.
- R3: Op codes: 0 = add, 1 = add with carry, 2 = subtract, 3 = subtract with borrow, 4 = AND, 5 = XOR, 6 = OR, 7 = compare, 8 = rotate left, 9 = rotate right. Codes 10 to 15 change neither `result` nor `flags`.
- R4: Add gives `acc + opnd`. Add with carry gives `acc + opnd + cin`. For both, the carry flag is the carry out of bit 7, and `cin` has no effect on plain add.
- R5: Subtract gives `acc - opnd`. Subtract with borrow gives `acc - opnd - cin`. For both, the carry flag is the borrow out of bit 7, the subtract flag is 1, and `cin` has no effect on plain subtract.
- R6: Compare sets every flag exactly as subtract would, and `result` keeps its previous value.
- R7: Flag byte layout: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Bits 5 and 3 are always 0.
- R8: For every operation except the rotates, sign equals bit 7 of the new result, and zero is 1 exactly when that result is 0x00.
- R9: Half-carry is the carry (for add) or the borrow (for subtract and compare) out of bit 3. It is forced to 1 by AND and to 0 by OR, XOR and both rotates.
- R10: After add, add with carry, subtract, subtract with borrow and compare, parity/overflow is 1 exactly when two's-complement signed overflow occurred.
- R11: After AND, OR and XOR, parity/overflow is 1 when the result holds an even number of 1 bits. Carry and subtract are cleared.
- R12: Rotate left moves `cin` into bit 0 and old bit 7 into carry. Rotate right moves `cin` into bit 7 and old bit 0 into carry. Both clear half-carry and subtract, and keep sign, zero and parity/overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the result and flag registers |
| op | input | 4 | Operation code (see R3) |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| cin | input | 1 | Incoming carry/borrow, also the rotate fill bit |
| result | output | 8 | Registered result |
| flags | output | 8 | Registered condition flags (see R7) |

## Verification
The hardest situation to reach from the ports is a rotate that must preserve sign, zero and parity/overflow. Those three flags only show their held values if an earlier operation has left them in a known, non-trivial pattern. The bench therefore runs an XOR that produces zero immediately before a rotate right, and chains a rotate left straight after it. This makes the preserved zero and parity bits visible, distinct from the freshly written carry. The bench sets up compare the same way: a result with a distinctive value is left in the register beforehand, so a stray write-back would show.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8,
    OP_RRC = 4'd9
  } alu_op_e;

  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_H  = 4;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic pv;
    logic n;
    logic c;
  } cond_t;

  function automatic logic [7:0] cond_to_byte(cond_t f);
    logic [7:0] b;
    b        = 8'h00;
    b[FB_S]  = f.s;
    b[FB_Z]  = f.z;
    b[FB_H]  = f.h;
    b[FB_PV] = f.pv;
    b[FB_N]  = f.n;
    b[FB_C]  = f.c;
    return b;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cy_in,
  output logic [DW-1:0] sum,
  output logic          cy_out,
  output logic          half_out,
  output logic          ovf
);
  localparam int HW  = DW / 2;
  localparam int MSB = DW - 1;

  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   wide;
  logic [HW:0]   low;

  always_comb begin
    b_eff    = sub ? ~b : b;
    c_eff    = sub ? ~cy_in : cy_in;
    wide     = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    low      = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
    sum      = wide[DW-1:0];
    cy_out   = sub ? ~wide[DW] : wide[DW];
    half_out = sub ? ~low[HW] : low[HW];
    ovf      = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    kind,   // 0 and, 1 xor, 2 or
  output logic [DW-1:0] res,
  output logic          even_par
);
  always_comb begin
    unique case (kind)
      2'd0:    res = a & b;
      2'd1:    res = a ^ b;
      default: res = a | b;
    endcase
    even_par = ~(^res);
  end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          fill,
  input  logic          left,
  output logic [DW-1:0] res,
  output logic          out_bit
);
  always_comb begin
    if (left) begin
      res     = {a[DW-2:0], fill};
      out_bit = a[DW-1];
    end else begin
      res     = {fill, a[DW-1:1]};
      out_bit = a[0];
    end
  end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [3:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  output logic [DW-1:0] result,
  output logic [7:0]    flags
);
  localparam int MSB = DW - 1;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  logic is_arith, is_sub, is_logic, is_rot, op_known, use_cin, writes_res;
  always_comb begin
    is_sub   = (op_e == OP_SUB) || (op_e == OP_SBC) || (op_e == OP_CMP);
    is_arith = is_sub || (op_e == OP_ADD) || (op_e == OP_ADC);
    is_logic = (op_e == OP_AND) || (op_e == OP_XOR) || (op_e == OP_OR);
    is_rot   = (op_e == OP_RLC) || (op_e == OP_RRC);
    op_known = is_arith || is_logic || is_rot;
    use_cin  = (op_e == OP_ADC) || (op_e == OP_SBC);
    writes_res = op_known && (op_e != OP_CMP);
  end

  // arithmetic path
  logic [DW-1:0] ar_sum;
  logic          ar_c, ar_h, ar_v;
  alu_addsub #(.DW(DW)) u_addsub (
    .a(acc), .b(opnd), .sub(is_sub), .cy_in(use_cin & cin),
    .sum(ar_sum), .cy_out(ar_c), .half_out(ar_h), .ovf(ar_v)
  );

  // logical path
  logic [1:0]    lg_kind;
  logic [DW-1:0] lg_res;
  logic          lg_par;
  always_comb begin
    unique case (op_e)
      OP_AND:  lg_kind = 2'd0;
      OP_XOR:  lg_kind = 2'd1;
      default: lg_kind = 2'd2;
    endcase
  end
  alu_bitwise #(.DW(DW)) u_bitwise (
    .a(acc), .b(opnd), .kind(lg_kind), .res(lg_res), .even_par(lg_par)
  );

  // rotate path
  logic [DW-1:0] rt_res;
  logic          rt_c;
  alu_rotate #(.DW(DW)) u_rotate (
    .a(acc), .fill(cin), .left(op_e == OP_RLC), .res(rt_res), .out_bit(rt_c)
  );

  cond_t         fl_q, fl_d;
  logic [DW-1:0] res_q, res_d, val;

  always_comb begin
    fl_d  = fl_q;
    res_d = res_q;
    val   = ar_sum;
    if (is_arith) begin
      val     = ar_sum;
      fl_d.s  = ar_sum[MSB];
      fl_d.z  = (ar_sum == '0);
      fl_d.h  = ar_h;
      fl_d.pv = ar_v;
      fl_d.n  = is_sub;
      fl_d.c  = ar_c;
    end else if (is_logic) begin
      val     = lg_res;
      fl_d.s  = lg_res[MSB];
      fl_d.z  = (lg_res == '0);
      fl_d.h  = (op_e == OP_AND);
      fl_d.pv = lg_par;
      fl_d.n  = 1'b0;
      fl_d.c  = 1'b0;
    end else if (is_rot) begin
      val     = rt_res;
      fl_d.h  = 1'b0;
      fl_d.n  = 1'b0;
      fl_d.c  = rt_c;
    end
    if (writes_res) res_d = val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      fl_q  <= '0;
    end else if (en) begin
      res_q <= res_d;
      fl_q  <= fl_d;
    end
  end

  assign result = res_q;
  assign flags  = cond_to_byte(fl_q);

  // ---------------- assertions ----------------
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result) && $stable(flags)));

  a_r3_unknown_code_no_change: assert property (@(posedge clk) disable iff (rst)
    (en && op >= 4'd10) |=> ($stable(result) && $stable(flags)));

  a_r6_cmp_keeps_result: assert property (@(posedge clk) disable iff (rst)
    (en && op == 4'd7) |=> $stable(result));

  a_r5_sub_sets_n: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 4'd2 || op == 4'd3 || op == 4'd7)) |=> flags[FB_N]);

  a_r11_logic_clears_cn: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 4'd4 || op == 4'd5 || op == 4'd6)) |=> (!flags[FB_C] && !flags[FB_N]));

  a_r12_rot_keeps_szp: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 4'd8 || op == 4'd9)) |=>
      (flags[FB_S] == $past(flags[FB_S]) && flags[FB_Z] == $past(flags[FB_Z]) &&
       flags[FB_PV] == $past(flags[FB_PV])));

  a_r8_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
    (en && op != 4'd7 && op <= 4'd6) |=> (flags[FB_Z] == (result == '0)));

  a_r7_reserved_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (flags[5] == 1'b0 && flags[3] == 1'b0));

endmodule

// File: tb/accum_alu_tb.sv
module accum_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, en, cin;
  logic [3:0] op;
  logic [7:0] acc, opnd;
  logic [7:0] result, flags;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_alu u_dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .acc(acc), .opnd(opnd),
    .cin(cin), .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // drive one operation, then check both outputs after the capturing edge
  task automatic step(input logic e, input logic [3:0] o, input logic [7:0] a,
                      input logic [7:0] b, input logic c,
                      input logic [7:0] exp_res, input logic [7:0] exp_fl,
                      input string tag);
    @(negedge clk);
    en = e; op = o; acc = a; opnd = b; cin = c;
    @(negedge clk);
    en = 1'b0;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " flags"}, flags, exp_fl);
  endtask

  task automatic t_reset;
    rst = 1'b1; en = 1'b0; op = 4'd0; acc = 8'h00; opnd = 8'h00; cin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, 8'h00);
    chk("R1 reset flags", flags, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_add;
    step(1, 4'd1, 8'h22, 8'h66, 1, 8'h89, 8'h84, "R4 R10 adc overflow");
    step(1, 4'd0, 8'h22, 8'h33, 1, 8'h55, 8'h00, "R4 add ignores cin");
    step(1, 4'd0, 8'hFF, 8'h01, 0, 8'h00, 8'h51, "R4 R8 R9 add wrap");
    step(1, 4'd0, 8'h0F, 8'h01, 0, 8'h10, 8'h10, "R9 half-carry");
  endtask

  task automatic t_sub;
    step(1, 4'd3, 8'h40, 8'h3F, 1, 8'h00, 8'h52, "R5 sbc to zero");
    step(1, 4'd2, 8'h40, 8'h44, 1, 8'hFC, 8'h93, "R5 R8 sub borrow");
    step(1, 4'd2, 8'h80, 8'h01, 0, 8'h7F, 8'h16, "R10 sub overflow");
  endtask

  task automatic t_cmp;
    step(1, 4'd7, 8'h44, 8'h44, 0, 8'h7F, 8'h42, "R6 cmp equal");
    step(1, 4'd7, 8'h10, 8'h20, 0, 8'h7F, 8'h83, "R6 cmp less");
  endtask

  task automatic t_logic;
    step(1, 4'd4, 8'h09, 8'h80, 1, 8'h00, 8'h54, "R11 R9 and zero even");
    step(1, 4'd4, 8'h81, 8'h88, 0, 8'h80, 8'h90, "R11 and odd");
    step(1, 4'd5, 8'h96, 8'h5D, 0, 8'hCB, 8'h80, "R11 xor odd");
    step(1, 4'd6, 8'h44, 8'h11, 1, 8'h55, 8'h04, "R11 or even");
    step(1, 4'd5, 8'h12, 8'h12, 0, 8'h00, 8'h44, "R11 xor zero");
  endtask

  task automatic t_rotate;
    // prior flags 0x44: zero and parity must survive
    step(1, 4'd9, 8'hE1, 8'h00, 0, 8'h70, 8'h45, "R12 rotate right");
    step(1, 4'd8, 8'h76, 8'h00, 1, 8'hED, 8'h44, "R12 rotate left");
  endtask

  task automatic t_hold;
    step(0, 4'd0, 8'h01, 8'h01, 0, 8'hED, 8'h44, "R2 disabled add");
    step(1, 4'd12, 8'h33, 8'h55, 1, 8'hED, 8'h44, "R3 unused code");
    step(1, 4'd15, 8'h00, 8'h00, 0, 8'hED, 8'h44, "R3 unused code 15");
  endtask

  task automatic t_layout;
    step(1, 4'd6, 8'hFF, 8'h00, 0, 8'hFF, 8'h84, "R7 R8 flag layout");
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_rotate();
    t_hold();
    t_layout();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule